// File: doc/BRIEF.md
# Single-Word Register-Programmed SPI Master

This block is a memory-mapped serial peripheral master. Software reaches it through a plain 32-bit register port: an address, a write strobe, write data, and read data that follows the address combinationally. The block drives a serial clock, a serial data output and one slave-select line, and it samples a serial data input. It also has a level interrupt.

Before a transfer, software programs the following:
- the number of bits per word;
- whether the least or the most significant bit goes first;
- which serial-clock edge launches outgoing data and which edge captures incoming data, chosen independently;
- the clock idle level and the clock divider;
- a number of idle serial-clock periods that follow each word.

Software then writes the outgoing word and sets the start bit. The block shifts one word and waits out the idle periods. It then drops the busy bit, sets a sticky completion flag and, if enabled, raises the interrupt. The received word is read back from the same address that takes the outgoing word.

The slave-select line is under direct software control, with a selectable active level. A two-bit word-count field is stored and read back but has no effect on the transfer. Each start shifts exactly one word.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, every register reads 0, the serial clock is low, the slave select is high (inactive, active-low) and the interrupt is low.
- R2: In the select register at offset 0x08, bit 0 asserts the slave select and bit 2 sets its active level (1 = high). The pin equals bit 2 when bit 0 is set, and the inverse of bit 2 otherwise.
- R3: The serial clock rests at control bit 31 while idle. During a word of N bits it makes exactly 2N transitions, each (divider+1) system clocks apart, with the divider at offset 0x04.
- R4: Control bits 7:3 give N, and 0 means 32. With control bit 10 clear, transmit-register bits N-1 down to 0 leave in that order.
- R5: With control bit 10 set, transmit-register bits 0 up to N-1 leave in that order.
- R6: Control bit 2 set makes falling edges launch outgoing data, otherwise rising edges do. Control bit 1 set makes falling edges capture incoming data, otherwise rising edges do. The first bit is presented at start, and a launch edge that is the very first clock transition does not advance the data.
- R7: Offset 0x10 reads the received word, zero-extended above bit N-1. In MSB-first mode the first captured bit lands in bit N-1. In LSB-first mode it lands in bit 0.
- R8: Writing control bit 0 = 1 while idle starts a transfer. Bit 0 reads 1 from the cycle after that write for exactly (2N + 2S)(divider+1) + 1 cycles, where S is control bits 15:12.
- R9: Control bit 16 sets in the cycle the busy bit drops. The interrupt output equals bit 16 AND control bit 17.
- R10: Writing control bit 16 = 1 clears it. Writing 0 there leaves it unchanged. All other control fields read back as last written.
- R11: While busy, a control write changes only bit 17 and the bit-16 clear, a start request is ignored, and writes to offset 0x10 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (5) | Register byte offset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| irq | output | 1 | Level interrupt: completion flag and enable |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ssel | output | 1 | Slave select |

## Verification
A corrupted bit counter or a wrong edge-type decision shows at once on the pins. The serial clock makes the wrong number of transitions, or the data line moves on the wrong edge. The slave model catches this within the word, and the busy bit stays high for the wrong number of cycles. A wrong index or bit-order choice shows as a bit-reversed or shifted word in the sampled output or in the received register. The bench reads that register right after busy drops. A fault in the frozen-configuration or write-one-to-clear logic shows as a changed control readback, or a wrong interrupt level, in the first read after completion.

// File: rtl/spim_pkg.sv
package spim_pkg;
  // control register field positions (software decodes these)
  localparam int CTL_GO   = 0;
  localparam int CTL_RXF  = 1;
  localparam int CTL_TXF  = 2;
  localparam int CTL_LEN  = 3;
  localparam int CTL_CNT  = 8;
  localparam int CTL_LSB  = 10;
  localparam int CTL_SLP  = 12;
  localparam int CTL_DONE = 16;
  localparam int CTL_IE   = 17;
  localparam int CTL_CPOL = 31;
  localparam int SEL_ON   = 0;
  localparam int SEL_LVL  = 2;

  localparam int OFF_CTL = 'h00;
  localparam int OFF_DIV = 'h04;
  localparam int OFF_SEL = 'h08;
  localparam int OFF_DAT = 'h10;

  typedef struct packed {
    logic       cpol;
    logic       ie;
    logic [3:0] sleep;
    logic       lsb;
    logic [1:0] cnt;
    logic [4:0] len;
    logic       txf;
    logic       rxf;
  } spim_cfg_t;

  // position in the data word of the k-th bit on the wire
  function automatic logic [4:0] wire_pos(input logic lsb, input logic [5:0] n,
                                          input logic [5:0] k);
    logic [5:0] p;
    p = lsb ? k : (n - 6'd1 - k);
    return p[4:0];
  endfunction
endpackage

// File: rtl/spim_tick.sv
module spim_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!run || tick)      cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  spim_cfg_t         cfg,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              last,
  output logic              sclk,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);
  localparam int CW = $clog2(4 * DATA_W + 32);

  logic [5:0]    nbits;
  logic [CW-1:0] edges, total, half_q;
  logic [5:0]    tx_k, rx_k;
  logic          sclk_q, mosi_q, busy_q;
  logic [DATA_W-1:0] rx_q;
  logic          nxt_lvl, edge_now, is_launch, is_capt;

  assign nbits     = (cfg.len == 5'd0) ? 6'd32 : {1'b0, cfg.len};
  assign edges     = CW'({nbits, 1'b0});
  assign total     = edges + CW'({cfg.sleep, 1'b0});
  assign nxt_lvl   = ~sclk_q;
  assign edge_now  = busy_q && tick && (half_q < edges);
  assign is_launch = nxt_lvl ? !cfg.txf : cfg.txf;
  assign is_capt   = nxt_lvl ? !cfg.rxf : cfg.rxf;
  assign last      = busy_q && tick && (half_q == total - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; half_q <= '0; tx_k <= '0; rx_k <= '0;
      sclk_q <= 1'b0; mosi_q <= 1'b0; rx_q <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      half_q <= '0;
      tx_k   <= '0;
      rx_k   <= '0;
      rx_q   <= '0;
      sclk_q <= cfg.cpol;
      mosi_q <= tx_word[wire_pos(cfg.lsb, nbits, 6'd0)];
    end else if (busy_q) begin
      if (tick) begin
        half_q <= half_q + 1'b1;
        if (last) busy_q <= 1'b0;
      end
      if (edge_now) begin
        sclk_q <= nxt_lvl;
        if (is_launch && half_q != '0 && (tx_k + 6'd1) < nbits) begin
          tx_k   <= tx_k + 6'd1;
          mosi_q <= tx_word[wire_pos(cfg.lsb, nbits, tx_k + 6'd1)];
        end
        if (is_capt) begin
          rx_q[wire_pos(cfg.lsb, nbits, rx_k)] <= miso;
          rx_k <= rx_k + 6'd1;
        end
      end
    end else begin
      sclk_q <= cfg.cpol;
    end
  end

  assign busy    = busy_q;
  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign rx_word = rx_q;
endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DIV_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              eng_busy,
  input  logic              eng_last,
  input  logic [DATA_W-1:0] rx_word,
  output spim_cfg_t         cfg,
  output logic [DATA_W-1:0] tx_word,
  output logic [DIV_W-1:0]  div,
  output logic              go,
  output logic              busy_any,
  output logic              done,
  output logic              sel_on,
  output logic              sel_lvl
);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFF_CTL);
  localparam logic [ADDR_W-1:0] A_DIV = ADDR_W'(OFF_DIV);
  localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(OFF_SEL);
  localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(OFF_DAT);

  logic wr_ctl, wr_div, wr_sel, wr_dat;
  logic [DATA_W-1:0] ctl_rd;

  assign wr_ctl   = bus_we && bus_addr == A_CTL;
  assign wr_div   = bus_we && bus_addr == A_DIV;
  assign wr_sel   = bus_we && bus_addr == A_SEL;
  assign wr_dat   = bus_we && bus_addr == A_DAT;
  assign busy_any = go | eng_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0; tx_word <= '0; div <= '0; go <= 1'b0;
      done <= 1'b0; sel_on <= 1'b0; sel_lvl <= 1'b0;
    end else begin
      go <= wr_ctl && !busy_any && bus_wdata[CTL_GO];
      if (wr_ctl) begin
        cfg.ie <= bus_wdata[CTL_IE];
        if (!busy_any) begin
          cfg.cpol  <= bus_wdata[CTL_CPOL];
          cfg.sleep <= bus_wdata[CTL_SLP +: 4];
          cfg.lsb   <= bus_wdata[CTL_LSB];
          cfg.cnt   <= bus_wdata[CTL_CNT +: 2];
          cfg.len   <= bus_wdata[CTL_LEN +: 5];
          cfg.txf   <= bus_wdata[CTL_TXF];
          cfg.rxf   <= bus_wdata[CTL_RXF];
        end
      end
      if (eng_last)                            done <= 1'b1;
      else if (wr_ctl && bus_wdata[CTL_DONE])  done <= 1'b0;
      if (wr_div) div <= bus_wdata[DIV_W-1:0];
      if (wr_sel) begin
        sel_on  <= bus_wdata[SEL_ON];
        sel_lvl <= bus_wdata[SEL_LVL];
      end
      if (wr_dat && !busy_any) tx_word <= bus_wdata;
    end
  end

  always_comb begin
    ctl_rd = '0;
    ctl_rd[CTL_GO]       = busy_any;
    ctl_rd[CTL_RXF]      = cfg.rxf;
    ctl_rd[CTL_TXF]      = cfg.txf;
    ctl_rd[CTL_LEN +: 5] = cfg.len;
    ctl_rd[CTL_CNT +: 2] = cfg.cnt;
    ctl_rd[CTL_LSB]      = cfg.lsb;
    ctl_rd[CTL_SLP +: 4] = cfg.sleep;
    ctl_rd[CTL_DONE]     = done;
    ctl_rd[CTL_IE]       = cfg.ie;
    ctl_rd[CTL_CPOL]     = cfg.cpol;
  end

  always_comb begin
    case (bus_addr)
      A_CTL:   bus_rdata = ctl_rd;
      A_DIV:   bus_rdata = DATA_W'(div);
      A_SEL:   bus_rdata = DATA_W'({sel_lvl, 1'b0, sel_on});
      A_DAT:   bus_rdata = rx_word;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_ssel
);
  localparam int DATA_W = 32;

  spim_cfg_t         cfg;
  logic [DATA_W-1:0] tx_word, rx_word;
  logic [DIV_W-1:0]  div;
  logic go, busy_any, done, sel_on, sel_lvl;
  logic eng_busy, eng_last, tick;

  spim_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_busy(eng_busy),
    .eng_last(eng_last), .rx_word(rx_word), .cfg(cfg), .tx_word(tx_word),
    .div(div), .go(go), .busy_any(busy_any), .done(done),
    .sel_on(sel_on), .sel_lvl(sel_lvl));

  spim_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(eng_busy), .div(div), .tick(tick));

  spim_engine #(.DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .start(go), .cfg(cfg), .tx_word(tx_word),
    .tick(tick), .miso(spi_miso), .busy(eng_busy), .last(eng_last),
    .sclk(spi_sclk), .mosi(spi_mosi), .rx_word(rx_word));

  assign spi_ssel = sel_on ? sel_lvl : ~sel_lvl;
  assign irq      = done & cfg.ie;
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              busy_any,
  input logic              eng_busy,
  input logic              tick,
  input logic              done,
  input logic              irq,
  input logic              sclk,
  input logic              mosi,
  input logic              cpol,
  input logic [4:0]        len,
  input logic [31:0]       tx_word
);
  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == '0 && bus_wdata[0] && !busy_any) |=> busy_any); // R8

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(eng_busy) && !eng_busy)); // R9

  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done); // R9

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_any && $past(busy_any)) |-> ($stable(len) && $stable(tx_word))); // R11

  AST_SCLK_IDLE_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_busy && $past(!eng_busy) && $stable(cpol)) |-> (sclk == cpol)); // R3

  AST_MOSI_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && $past(eng_busy) && !$past(tick)) |-> $stable(mosi)); // R6
endmodule

bind spim_ctrl spim_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .busy_any(busy_any), .eng_busy(eng_busy),
  .tick(tick), .done(done), .irq(irq), .sclk(spi_sclk), .mosi(spi_mosi),
  .cpol(cfg.cpol), .len(cfg.len), .tx_word(tx_word));

// File: tb/test_spim_ctrl.sv
`timescale 1ns/1ps
module test_spim_ctrl;
  localparam int ADDR_W = 5;
  localparam logic [4:0] A_CTL = 5'h00, A_DIV = 5'h04, A_SEL = 5'h08, A_DAT = 5'h10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, spi_sclk, spi_mosi, spi_ssel;
  logic spi_miso = 1'b0;

  int checks = 0, errors = 0;

  spim_ctrl i_spim_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_ssel(spi_ssel));

  always #2.5 clk = ~clk;

  // slave model
  logic [31:0] s_send, s_got;
  int s_edges, s_midx, s_n;
  bit s_on = 0, s_txf, s_rxf;

  always @(spi_sclk) if (s_on) begin
    s_edges++;
    if (spi_sclk ? s_txf : !s_txf) s_got = {s_got[30:0], spi_mosi};
    if ((spi_sclk ? s_rxf : !s_rxf) && s_edges > 1) begin
      s_midx++;
      if (s_midx < s_n) spi_miso <= #1 s_send[s_n-1-s_midx];
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] mask_n(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  function automatic logic [31:0] rev_n(input logic [31:0] w, input int n);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = w[n-1-i];
    return r;
  endfunction

  function automatic logic [31:0] mk_cfg(input bit cpol, txf, rxf, lsb, ie,
                                         input int len, input int slp);
    return (32'(cpol) << 31) | (32'(ie) << 17) | (32'(slp) << 12) |
           (32'(lsb) << 10) | (32'd1 << 8) | (32'(len) << 3) |
           (32'(txf) << 2) | (32'(rxf) << 1);
  endfunction

  task automatic arm_slave(input logic [31:0] sw, input int n, input bit txf, rxf);
    s_send = sw; s_n = n; s_got = '0; s_edges = 0; s_midx = 0;
    s_txf = txf; s_rxf = rxf; spi_miso = sw[n-1]; s_on = 1;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    bus_addr = A_CTL; #1;
    while (bus_rdata[0]) begin
      cyc++;
      @(negedge clk); bus_addr = A_CTL; #1;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CTL, v); check(v == 0, "R1 ctrl", v, 0);
    rd(A_DAT, v); check(v == 0, "R1 rx", v, 0);
    check(spi_sclk == 0, "R1 sclk", 32'(spi_sclk), 0);
    check(spi_ssel == 1, "R1 ssel", 32'(spi_ssel), 1);
    check(irq == 0, "R1 irq", 32'(irq), 0);
  endtask

  task automatic t_select();
    wr(A_SEL, 32'h1); #1 check(spi_ssel == 0, "R2 low-active on", 32'(spi_ssel), 0);
    wr(A_SEL, 32'h5); #1 check(spi_ssel == 1, "R2 high-active on", 32'(spi_ssel), 1);
    wr(A_SEL, 32'h4); #1 check(spi_ssel == 0, "R2 high-active off", 32'(spi_ssel), 0);
  endtask

  task automatic t_xfer(input bit cpol, txf, rxf, lsb, ie, input int len,
                        input int dv, input int slp, input logic [31:0] txw,
                        input logic [31:0] sw);
    int n = (len == 0) ? 32 : len;
    int cyc, exp_cyc;
    logic [31:0] cfg, v, eg, er;
    string ttag = lsb ? "R5 tx order" : "R4 tx order";
    cfg = mk_cfg(cpol, txf, rxf, lsb, ie, len, slp);
    wr(A_DIV, 32'(dv));
    wr(A_CTL, cfg);
    wr(A_DAT, txw);
    repeat (3) @(negedge clk);
    check(spi_sclk == cpol, "R3 idle level", 32'(spi_sclk), 32'(cpol));
    arm_slave(sw, n, txf, rxf);
    wr(A_CTL, cfg | 32'h1);
    wait_idle(cyc);
    s_on = 0;
    exp_cyc = (2 * n + 2 * slp) * (dv + 1) + 1;
    check(cyc == exp_cyc, "R8 busy length", 32'(cyc), 32'(exp_cyc));
    check(s_edges == 2 * n, "R3 edge count", 32'(s_edges), 32'(2 * n));
    eg = lsb ? rev_n(txw, n) : (txw & mask_n(n));
    check(s_got == eg, ttag, s_got, eg);
    rd(A_DAT, v);
    er = lsb ? rev_n(sw, n) : (sw & mask_n(n));
    check(v == er, "R7 rx word", v, er);
    rd(A_CTL, v);
    check(v == (cfg | 32'h1_0000), "R9 done flag", v, cfg | 32'h1_0000);
    check(irq == ie, "R9 irq level", 32'(irq), 32'(ie));
    wr(A_CTL, v);
    rd(A_CTL, v);
    check(v == cfg, "R10 w1c clear", v, cfg);
    check(irq == 0, "R10 irq after clear", 32'(irq), 0);
  endtask

  task automatic t_busy_writes();
    logic [31:0] cfg, v, alt;
    int cyc;
    cfg = mk_cfg(0, 1, 0, 0, 0, 16, 0);
    wr(A_DIV, 32'd3);
    wr(A_CTL, cfg);
    wr(A_DAT, 32'h0000_A5C3);
    repeat (2) @(negedge clk);
    arm_slave(32'h1234, 16, 1, 0);
    wr(A_CTL, cfg | 32'h1);
    repeat (8) @(negedge clk);
    alt = mk_cfg(1, 0, 1, 1, 1, 4, 7) | 32'h1;
    wr(A_CTL, alt);
    wr(A_DAT, 32'hFFFF_FFFF);
    wait_idle(cyc);
    s_on = 0;
    check(s_edges == 32, "R11 length frozen", 32'(s_edges), 32);
    check(s_got == 32'h0000_A5C3, "R11 tx frozen", s_got, 32'h0000_A5C3);
    rd(A_CTL, v);
    check(v == (cfg | 32'h2_0000 | 32'h1_0000), "R11 only ie taken", v,
          cfg | 32'h3_0000);
    check(irq == 1, "R9 irq enabled mid-word", 32'(irq), 1);
    wr(A_CTL, v & ~32'h1_0000);
    rd(A_CTL, v);
    check(v[16] == 1, "R10 zero keeps flag", 32'(v[16]), 1);
    wr(A_CTL, v);
    rd(A_CTL, v);
    check(v[16] == 0, "R10 one clears flag", 32'(v[16]), 0);
    rd(A_DIV, v);
    check(v == 32'd3, "R10 divider readback", v, 3);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_select();
    t_xfer(0, 1, 0, 0, 1, 8, 1, 0, 32'h0000_00B6, 32'h0000_0059);
    t_xfer(1, 0, 1, 0, 0, 12, 0, 3, 32'h0000_0E31, 32'h0000_0A7C);
    t_xfer(0, 0, 0, 1, 1, 0, 2, 1, 32'hC0DE_1F25, 32'h8E41_7B93);
    t_xfer(1, 1, 1, 1, 0, 5, 0, 0, 32'hFFFF_FFF3, 32'h0000_0016);
    t_xfer(0, 1, 1, 0, 0, 1, 0, 2, 32'h0000_0001, 32'h0000_0001);
    t_busy_writes();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule